// File: doc/BRIEF.md
# Low-Power Mode Sequencing Controller

This block is the system power-mode state machine of a microcontroller-class device. It moves the device between Active, Sleep, three deep-sleep variants (state-retaining, RAM-retaining and fully off) and Hibernate. It also passes through a reset state after power-on, after an external reset, and after any wake that requires a cold restart. Software asks for a mode through a request interface: a wait-for-interrupt strobe with a deep flag and a variant select, or a direct hibernate write. The controller then drives encoded target states onto three power-domain policy units (main, CPU subsystem, SRAM), controls the I/O freeze, and reports how the CPU should restart.

Regulators, clock generators and boot firmware are outside the block. Two parameterised dwell timers stand in for them: one sets how long reset is held, and the other sets the wake ramp before Active. Each low-power mode accepts its own set of wake sources. Per-source enables are captured at the moment of entry. Hibernate also watches a parameterised group of wake pins, each with its own polarity.

Top module: `lpm_seq`

## Requirements
- R1: While `rst_n` is low and for `RST_CYCLES` clock edges after it rises, `mode_o` reads 0 (reset), `sys_rst` is 1 and `boot_kind` is 2 (cold). The next edge gives `mode_o`=1 (Active).
- R2: Mode codes are 0 reset, 1 Active, 2 Sleep, 3 Deep Sleep, 4 Deep Sleep-RAM, 5 Deep Sleep-OFF, 6 Hibernate and 7 wake ramp. In Active, `hib_wr` enters Hibernate and takes priority over `wfi`. A `wfi` with `sleep_deep`=0 enters Sleep.
- R3: In Active, `wfi` with `sleep_deep`=1 enters a deep mode on the next edge when `lp_ready`=1 and `dbg_attached`=0. `ds_sel` selects the mode: 0 gives Deep Sleep, 1 gives Deep Sleep-RAM, 2 gives Deep Sleep-OFF, and 3 gives Deep Sleep.
- R4: A deep request made while `lp_ready`=0 or `dbg_attached`=1 parks the controller in Sleep. It moves to the requested deep mode on the first edge at which both conditions clear.
- R5: Domain codes are 0 ON, 1 full retention, 2 memory retention and 3 OFF. The triple main/cpu/sram is 1/1/2 in Deep Sleep, 2/3/2 in Deep Sleep-RAM, and 3/3/3 in Deep Sleep-OFF and in Hibernate. Every other mode gives 0/0/0.
- R6: In Sleep, `irq` returns the controller to Active on the next edge with `boot_kind`=0 (resume), and cancels any parked deep request.
- R7: Deep Sleep wakes on any enabled source among `wake_src` bits 0 GPIO, 1 comparator, 2 serial, 3 watchdog and 4 RTC. It enters the ramp and then Active with `boot_kind`=0. `dbg_wake` returns it to Sleep, and `irq` has no effect.
- R8: Deep Sleep-RAM and Deep Sleep-OFF ignore the comparator (bit 1) and accept the other four sources. Deep Sleep-RAM goes through the ramp to Active with `boot_kind`=1 (warm). Deep Sleep-OFF goes to reset with `boot_kind`=2.
- R9: Hibernate wakes only on comparator, watchdog or RTC, or on any `hib_pin[i]` that equals `hib_pol[i]` while enable bit 5 is set. The wake goes to reset with `boot_kind`=2.
- R10: `wake_en` bits 0 to 4 gate the matching `wake_src` bits, and bit 5 gates the hibernate pins. They are captured on entry to a deep mode or Hibernate, and later changes have no effect until the next entry.
- R11: `io_freeze` rises on entry to Deep Sleep-OFF or Hibernate and stays high through the following reset. It clears only after an `unfreeze` pulse while in Active, or on `rst_n`.
- R12: `ext_rst` forces reset from any mode on the next edge, with `boot_kind`=2. Reset then lasts `RST_CYCLES` edges after `ext_rst` falls.
- R13: The wake ramp lasts `RAMP_CYCLES` edges, with all domains ON, before Active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Power-on reset, active low, asynchronous |
| ext_rst | input | 1 | External reset request, synchronous |
| wfi | input | 1 | CPU wait-for-interrupt strobe |
| sleep_deep | input | 1 | Deep flag accompanying `wfi` |
| ds_sel | input | 2 | Deep-sleep variant select |
| hib_wr | input | 1 | Hibernate register write strobe |
| unfreeze | input | 1 | Software I/O unfreeze strobe |
| lp_ready | input | 1 | Low-power ready flag |
| dbg_attached | input | 1 | Debugger connected |
| irq | input | 1 | Any enabled CPU interrupt |
| dbg_wake | input | 1 | Debugger wake event |
| wake_src | input | 5 | Wake sources: GPIO, comparator, serial, watchdog, RTC |
| wake_en | input | 6 | Wake enables (bit 5 = hibernate pins) |
| hib_pin | input | HIB_PINS | Hibernate wake pins |
| hib_pol | input | HIB_PINS | Active level per wake pin |
| mode_o | output | 3 | Current mode code |
| main_pd | output | 2 | Main domain policy state |
| cpu_pd | output | 2 | CPU subsystem domain policy state |
| sram_pd | output | 2 | SRAM domain policy state |
| io_freeze | output | 1 | I/O freeze |
| boot_kind | output | 2 | Restart kind: resume, warm, cold |
| sys_rst | output | 1 | System reset, high while in reset |

## Verification
A corrupted mode register shows up on `mode_o` and on all three domain codes in the same cycle, because the domain codes are a pure decode of the mode. A lost parked request or captured enable stays hidden until the next wake event. At that point it shows one edge later as a wake that is missed or spurious. A wrong restart kind or freeze latch persists into Active, so it can be checked once the ramp or reset dwell has finished, `RAMP_CYCLES` or `RST_CYCLES` edges after the wake.

// File: rtl/lpm_seq_pkg.sv
package lpm_seq_pkg;

   typedef enum logic [2:0] {
      M_RESET  = 3'd0,
      M_ACTIVE = 3'd1,
      M_SLEEP  = 3'd2,
      M_DS     = 3'd3,
      M_DSRAM  = 3'd4,
      M_DSOFF  = 3'd5,
      M_HIB    = 3'd6,
      M_RAMP   = 3'd7
   } mode_e;

   typedef enum logic [1:0] {
      PD_ON   = 2'd0,
      PD_FRET = 2'd1,
      PD_MRET = 2'd2,
      PD_OFF  = 2'd3
   } pd_e;

   typedef enum logic [1:0] {
      BT_RESUME = 2'd0,
      BT_WARM   = 2'd1,
      BT_COLD   = 2'd2
   } boot_e;

   localparam int NSRC = 5;
   // source bit positions: 0 gpio, 1 comparator, 2 serial, 3 watchdog, 4 rtc
   localparam logic [NSRC-1:0] MASK_DS  = 5'b11111;
   localparam logic [NSRC-1:0] MASK_RET = 5'b11101;
   localparam logic [NSRC-1:0] MASK_HIB = 5'b11010;
   localparam int EN_W = NSRC + 1;

   function automatic mode_e deep_target(input logic [1:0] sel);
      case (sel)
         2'd1:    return M_DSRAM;
         2'd2:    return M_DSOFF;
         default: return M_DS;
      endcase
   endfunction

   function automatic logic is_low(input mode_e m);
      return (m == M_DS) || (m == M_DSRAM) || (m == M_DSOFF) || (m == M_HIB);
   endfunction

endpackage

// File: rtl/lpm_dwell_timer.sv
module lpm_dwell_timer #(
   parameter int W = 3
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         restart,
   output logic [W-1:0] cnt
);
   localparam logic [W-1:0] TOP = {W{1'b1}};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)            cnt <= '0;
      else if (restart)      cnt <= '0;
      else if (cnt != TOP)   cnt <= cnt + 1'b1;
   end
endmodule

// File: rtl/lpm_domain_map.sv
module lpm_domain_map
   import lpm_seq_pkg::*;
(
   input  mode_e      mode,
   output logic [1:0] main_pd,
   output logic [1:0] cpu_pd,
   output logic [1:0] sram_pd
);
   pd_e m, c, s;

   always_comb begin
      m = PD_ON; c = PD_ON; s = PD_ON;
      case (mode)
         M_DS:    begin m = PD_FRET; c = PD_FRET; s = PD_MRET; end
         M_DSRAM: begin m = PD_MRET; c = PD_OFF;  s = PD_MRET; end
         M_DSOFF,
         M_HIB:   begin m = PD_OFF;  c = PD_OFF;  s = PD_OFF;  end
         default: ;
      endcase
   end

   assign main_pd = m;
   assign cpu_pd  = c;
   assign sram_pd = s;
endmodule

// File: rtl/lpm_wake_filter.sv
module lpm_wake_filter
   import lpm_seq_pkg::*;
#(
   parameter int HIB_PINS = 2
) (
   input  mode_e               mode,
   input  logic [NSRC-1:0]     src,
   input  logic [EN_W-1:0]     en,
   input  logic [HIB_PINS-1:0] pin,
   input  logic [HIB_PINS-1:0] pol,
   output logic                wake
);
   logic [HIB_PINS-1:0] pin_hit;
   logic [NSRC-1:0]     gated;

   for (genvar i = 0; i < HIB_PINS; i++) begin : g_pin
      assign pin_hit[i] = ~(pin[i] ^ pol[i]);
   end

   assign gated = src & en[NSRC-1:0];

   always_comb begin
      case (mode)
         M_DS:           wake = |(gated & MASK_DS);
         M_DSRAM,
         M_DSOFF:        wake = |(gated & MASK_RET);
         M_HIB:          wake = (|(gated & MASK_HIB)) | (en[NSRC] & (|pin_hit));
         default:        wake = 1'b0;
      endcase
   end
endmodule

// File: rtl/lpm_seq.sv
module lpm_seq
   import lpm_seq_pkg::*;
#(
   parameter int RST_CYCLES  = 4,
   parameter int RAMP_CYCLES = 3,
   parameter int HIB_PINS    = 2
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                ext_rst,
   input  logic                wfi,
   input  logic                sleep_deep,
   input  logic [1:0]          ds_sel,
   input  logic                hib_wr,
   input  logic                unfreeze,
   input  logic                lp_ready,
   input  logic                dbg_attached,
   input  logic                irq,
   input  logic                dbg_wake,
   input  logic [4:0]          wake_src,
   input  logic [5:0]          wake_en,
   input  logic [HIB_PINS-1:0] hib_pin,
   input  logic [HIB_PINS-1:0] hib_pol,
   output logic [2:0]          mode_o,
   output logic [1:0]          main_pd,
   output logic [1:0]          cpu_pd,
   output logic [1:0]          sram_pd,
   output logic                io_freeze,
   output logic [1:0]          boot_kind,
   output logic                sys_rst
);
   localparam int CNT_MAX = (RST_CYCLES > RAMP_CYCLES) ? RST_CYCLES : RAMP_CYCLES;
   localparam int CW      = $clog2(CNT_MAX + 1);
   localparam logic [CW-1:0] RST_LAST  = CW'(RST_CYCLES - 1);
   localparam logic [CW-1:0] RAMP_LAST = CW'(RAMP_CYCLES - 1);

   if (RST_CYCLES < 1) begin : g_bad_rst
      $error("RST_CYCLES must be at least 1");
   end
   if (RAMP_CYCLES < 1) begin : g_bad_ramp
      $error("RAMP_CYCLES must be at least 1");
   end
   if (HIB_PINS < 1 || HIB_PINS > 8) begin : g_bad_pins
      $error("HIB_PINS must be within 1..8");
   end

   mode_e          state, nxt, flav_q;
   logic           pend_q, freeze_q;
   boot_e          boot_q, boot_nxt;
   logic [EN_W-1:0] en_q;
   logic [CW-1:0]  cnt;
   logic           wake, ok_deep, restart;

   assign ok_deep = lp_ready & ~dbg_attached;

   lpm_wake_filter #(.HIB_PINS(HIB_PINS)) u_wake (
      .mode (state),
      .src  (wake_src),
      .en   (en_q),
      .pin  (hib_pin),
      .pol  (hib_pol),
      .wake (wake)
   );

   lpm_domain_map u_map (
      .mode    (state),
      .main_pd (main_pd),
      .cpu_pd  (cpu_pd),
      .sram_pd (sram_pd)
   );

   assign restart = (nxt != state) | ext_rst;

   lpm_dwell_timer #(.W(CW)) u_dwell (
      .clk     (clk),
      .rst_n   (rst_n),
      .restart (restart),
      .cnt     (cnt)
   );

   // next mode
   always_comb begin
      nxt      = state;
      boot_nxt = boot_q;
      case (state)
         M_RESET:  if (cnt == RST_LAST) nxt = M_ACTIVE;
         M_ACTIVE: begin
            if (hib_wr)                          nxt = M_HIB;
            else if (wfi && sleep_deep && ok_deep) nxt = deep_target(ds_sel);
            else if (wfi)                        nxt = M_SLEEP;
         end
         M_SLEEP: begin
            if (irq) begin
               nxt      = M_ACTIVE;
               boot_nxt = BT_RESUME;
            end else if (pend_q && ok_deep) begin
               nxt = flav_q;
            end
         end
         M_DS: begin
            if (wake) begin
               nxt      = M_RAMP;
               boot_nxt = BT_RESUME;
            end else if (dbg_wake) begin
               nxt      = M_SLEEP;
               boot_nxt = BT_RESUME;
            end
         end
         M_DSRAM: if (wake) begin
            nxt      = M_RAMP;
            boot_nxt = BT_WARM;
         end
         M_DSOFF, M_HIB: if (wake) nxt = M_RESET;
         M_RAMP:  if (cnt == RAMP_LAST) nxt = M_ACTIVE;
         default: nxt = M_RESET;
      endcase
      if (ext_rst) nxt = M_RESET;
      if (nxt == M_RESET) boot_nxt = BT_COLD;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state    <= M_RESET;
         boot_q   <= BT_COLD;
         flav_q   <= M_DS;
         pend_q   <= 1'b0;
         en_q     <= '0;
         freeze_q <= 1'b0;
      end else begin
         state  <= nxt;
         boot_q <= boot_nxt;
         if (state == M_ACTIVE && wfi && sleep_deep)
            flav_q <= deep_target(ds_sel);
         if (state == M_ACTIVE && nxt == M_SLEEP)
            pend_q <= sleep_deep;
         else if (nxt != M_SLEEP)
            pend_q <= 1'b0;
         if (is_low(nxt) && !is_low(state))
            en_q <= wake_en;
         if ((nxt == M_DSOFF || nxt == M_HIB) && nxt != state)
            freeze_q <= 1'b1;
         else if (state == M_ACTIVE && unfreeze)
            freeze_q <= 1'b0;
      end
   end

   assign mode_o    = state;
   assign boot_kind = boot_q;
   assign io_freeze = freeze_q;
   assign sys_rst   = (state == M_RESET);

endmodule

// File: rtl/lpm_seq_chk.sv
module lpm_seq_chk #(
   parameter int HIB_PINS = 2
) (
   input logic       clk,
   input logic       rst_n,
   input logic       ext_rst,
   input logic       lp_ready,
   input logic       dbg_attached,
   input logic [2:0] mode_o,
   input logic [1:0] main_pd,
   input logic [1:0] cpu_pd,
   input logic [1:0] sram_pd,
   input logic       io_freeze,
   input logic [1:0] boot_kind,
   input logic       sys_rst
);
   a_r5_ds_domains: assert property (@(posedge clk) disable iff (!rst_n)
      mode_o == 3'd3 |-> main_pd == 2'd1 && cpu_pd == 2'd1 && sram_pd == 2'd2);

   a_r5_ram_domains: assert property (@(posedge clk) disable iff (!rst_n)
      mode_o == 3'd4 |-> main_pd == 2'd2 && cpu_pd == 2'd3 && sram_pd == 2'd2);

   a_r5_legal_codes: assert property (@(posedge clk) disable iff (!rst_n)
      cpu_pd != 2'd2 && sram_pd != 2'd1);

   a_r12_ext_reset: assert property (@(posedge clk) disable iff (!rst_n)
      ext_rst |=> mode_o == 3'd0 && sys_rst && boot_kind == 2'd2);

   a_r11_freeze_entry: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(io_freeze) |-> mode_o == 3'd5 || mode_o == 3'd6);

   a_r4_deep_ready: assert property (@(posedge clk) disable iff (!rst_n)
      (($past(mode_o) == 3'd1 || $past(mode_o) == 3'd2) &&
       (mode_o == 3'd3 || mode_o == 3'd4 || mode_o == 3'd5))
      |-> $past(lp_ready) && !$past(dbg_attached));

   a_r8_warm_ramp: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_o == 3'd7 && $past(mode_o) == 3'd4) |-> boot_kind == 2'd1);

   a_r9_hib_exit: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(mode_o) == 3'd6 && mode_o != 3'd6) |-> mode_o == 3'd0);
endmodule

bind lpm_seq lpm_seq_chk #(.HIB_PINS(HIB_PINS)) u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .ext_rst      (ext_rst),
   .lp_ready     (lp_ready),
   .dbg_attached (dbg_attached),
   .mode_o       (mode_o),
   .main_pd      (main_pd),
   .cpu_pd       (cpu_pd),
   .sram_pd      (sram_pd),
   .io_freeze    (io_freeze),
   .boot_kind    (boot_kind),
   .sys_rst      (sys_rst)
);

// File: tb/lpm_seq_tb.sv
module lpm_seq_tb;
   localparam int RSTC = 4;
   localparam int RMPC = 3;
   localparam int NP   = 2;

   logic clk = 1'b0;
   logic rst_n = 1'b0, ext_rst = 1'b0, wfi = 1'b0, sleep_deep = 1'b0;
   logic [1:0] ds_sel = '0;
   logic hib_wr = 1'b0, unfreeze = 1'b0, lp_ready = 1'b1, dbg_attached = 1'b0;
   logic irq = 1'b0, dbg_wake = 1'b0;
   logic [4:0] wake_src = '0;
   logic [5:0] wake_en = '0;
   logic [NP-1:0] hib_pin = '0, hib_pol = '0;
   logic [2:0] mode_o;
   logic [1:0] main_pd, cpu_pd, sram_pd, boot_kind;
   logic io_freeze, sys_rst;

   int n_vec = 0, n_bad = 0;
   bit done = 0;

   always #2.5 clk = ~clk;

   lpm_seq #(.RST_CYCLES(RSTC), .RAMP_CYCLES(RMPC), .HIB_PINS(NP)) u_dut (
      .clk(clk), .rst_n(rst_n), .ext_rst(ext_rst), .wfi(wfi), .sleep_deep(sleep_deep),
      .ds_sel(ds_sel), .hib_wr(hib_wr), .unfreeze(unfreeze), .lp_ready(lp_ready),
      .dbg_attached(dbg_attached), .irq(irq), .dbg_wake(dbg_wake), .wake_src(wake_src),
      .wake_en(wake_en), .hib_pin(hib_pin), .hib_pol(hib_pol), .mode_o(mode_o),
      .main_pd(main_pd), .cpu_pd(cpu_pd), .sram_pd(sram_pd), .io_freeze(io_freeze),
      .boot_kind(boot_kind), .sys_rst(sys_rst));

   task automatic check(input string req, input int act, input int exp);
      n_vec++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
      end
   endtask

   task automatic tick();
      @(posedge clk); #1;
   endtask

   // expected domain triple packed main*16+cpu*4+sram
   function automatic int pd_exp(input int m);
      case (m)
         3: return 1*16 + 1*4 + 2;
         4: return 2*16 + 3*4 + 2;
         5, 6: return 3*16 + 3*4 + 3;
         default: return 0;
      endcase
   endfunction

   task automatic check_pd(input string req, input int m);
      check(req, int'(main_pd)*16 + int'(cpu_pd)*4 + int'(sram_pd), pd_exp(m));
   endtask

   task automatic por();
      rst_n = 1'b0; ext_rst = 0; wfi = 0; sleep_deep = 0; ds_sel = 0; hib_wr = 0;
      unfreeze = 0; lp_ready = 1; dbg_attached = 0; irq = 0; dbg_wake = 0;
      wake_src = 0; wake_en = 0; hib_pin = 0; hib_pol = 0;
      tick(); tick();
      rst_n = 1'b1;
      repeat (RSTC) tick();
   endtask

   task automatic enter_deep(input int fl, input logic [5:0] en);
      wake_en = en; ds_sel = 2'(fl); sleep_deep = 1; wfi = 1;
      tick();
      wfi = 0; sleep_deep = 0;
   endtask

   function automatic bit deep_ok(input int fl, input int s);
      return (fl == 0) ? 1'b1 : (s != 1);
   endfunction

   function automatic bit hib_ok(input int s);
      return (s == 1) || (s == 3) || (s == 4);
   endfunction

   initial begin : watchdog
      #100000;
      if (!done) begin
         n_bad++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
         $finish;
      end
   end

   initial begin : main
      // R1 reset state and dwell
      rst_n = 0; tick(); tick(); rst_n = 1;
      check("R1 mode in reset", mode_o, 0);
      check("R1 sys_rst", sys_rst, 1);
      check("R1 boot cold", boot_kind, 2);
      check("R11 freeze clear after por", io_freeze, 0);
      check_pd("R5 reset domains", 0);
      repeat (RSTC-1) tick();
      check("R1 still reset", mode_o, 0);
      tick();
      check("R1 active after dwell", mode_o, 1);
      check("R1 sys_rst low", sys_rst, 0);

      // R3 / R5 / R7 / R8 / R10 / R13 deep sweep
      for (int fl = 0; fl < 3; fl++) begin
         for (int s = 0; s < 5; s++) begin
            for (int enb = 0; enb < 2; enb++) begin
               logic [5:0] en;
               bit exp_w;
               en = enb ? 6'h3f : (6'h3f & ~(6'd1 << s));
               exp_w = enb && deep_ok(fl, s);
               por();
               enter_deep(fl, en);
               check("R3 deep entry", mode_o, 3 + fl);
               check_pd("R5 deep domains", 3 + fl);
               if (fl == 2) check("R11 freeze on off entry", io_freeze, 1);
               wake_src = 5'(1 << s);
               tick();
               wake_src = 0;
               if (!exp_w) begin
                  check(fl == 0 ? "R10 disabled source ignored" : "R8 source ignored",
                        mode_o, 3 + fl);
               end else if (fl == 2) begin
                  check("R8 off wake to reset", mode_o, 0);
                  repeat (RSTC) tick();
                  check("R8 off wake active", mode_o, 1);
                  check("R8 off boot cold", boot_kind, 2);
                  check("R11 freeze held through reset", io_freeze, 1);
               end else begin
                  check("R13 ramp entered", mode_o, 7);
                  check_pd("R13 ramp domains on", 7);
                  repeat (RMPC-1) tick();
                  check("R13 ramp dwell", mode_o, 7);
                  tick();
                  check(fl == 0 ? "R7 ds wake active" : "R8 ram wake active", mode_o, 1);
                  check(fl == 0 ? "R7 boot resume" : "R8 boot warm", boot_kind, fl);
               end
            end
         end
      end

      // R9 hibernate source sweep
      for (int s = 0; s < 5; s++) begin
         por();
         hib_pol = 2'b11; hib_pin = 2'b00; wake_en = 6'h3f; hib_wr = 1;
         tick(); hib_wr = 0;
         check("R9 hib entry", mode_o, 6);
         check_pd("R5 hib domains", 6);
         check("R11 freeze on hib", io_freeze, 1);
         wake_src = 5'(1 << s); tick(); wake_src = 0;
         check("R9 hib source", mode_o, hib_ok(s) ? 0 : 6);
      end

      // R9 pin polarity sweep
      for (int pol = 0; pol < 4; pol++) begin
         for (int v = 0; v < 4; v++) begin
            bit hit;
            hit = ((~(v ^ pol)) & 3) != 0;
            por();
            hib_pol = 2'(pol); hib_pin = 2'(~pol); wake_en = 6'h3f; hib_wr = 1;
            tick(); hib_wr = 0;
            hib_pin = 2'(v); tick();
            check("R9 pin polarity", mode_o, hit ? 0 : 6);
            if (hit) check("R9 hib boot cold", boot_kind, 2);
         end
      end

      // R10 pin enable bit 5 off
      por();
      hib_pol = 2'b01; hib_pin = 2'b10; wake_en = 6'h1f; hib_wr = 1;
      tick(); hib_wr = 0; hib_pin = 2'b01; tick();
      check("R10 pin enable off", mode_o, 6);

      // R10 enables sampled at entry
      por();
      enter_deep(0, 6'h00);
      wake_en = 6'h3f; wake_src = 5'h1f; tick(); wake_src = 0;
      check("R10 sampled enables", mode_o, 3);

      // R4 not ready parks in sleep
      por();
      lp_ready = 0;
      enter_deep(1, 6'h3f);
      check("R4 parked in sleep", mode_o, 2);
      check_pd("R5 sleep domains", 2);
      repeat (3) tick();
      check("R4 still parked", mode_o, 2);
      lp_ready = 1; tick();
      check("R4 deep after ready", mode_o, 4);

      // R4 debugger attached parks
      por();
      dbg_attached = 1;
      enter_deep(0, 6'h3f);
      check("R4 dbg parks", mode_o, 2);
      dbg_attached = 0; tick();
      check("R4 deep after detach", mode_o, 3);

      // R6 irq cancels parked request
      por();
      lp_ready = 0;
      enter_deep(2, 6'h3f);
      irq = 1; tick(); irq = 0;
      check("R6 irq wake", mode_o, 1);
      check("R6 boot resume", boot_kind, 0);
      lp_ready = 1; tick();
      check("R6 request cancelled", mode_o, 1);

      // R2 plain sleep and hib priority
      por();
      wfi = 1; tick(); wfi = 0;
      check("R2 plain sleep", mode_o, 2);
      tick();
      check("R2 sleep holds", mode_o, 2);
      irq = 1; tick(); irq = 0;
      check("R6 sleep wake", mode_o, 1);
      hib_wr = 1; wfi = 1; sleep_deep = 1; tick();
      hib_wr = 0; wfi = 0; sleep_deep = 0;
      check("R2 hib priority", mode_o, 6);

      // R3 ds_sel 3
      por();
      enter_deep(3, 6'h3f);
      check("R3 sel3 deep sleep", mode_o, 3);

      // R7 irq ignored, debugger wake to sleep
      irq = 1; tick(); irq = 0;
      check("R7 irq ignored in ds", mode_o, 3);
      dbg_wake = 1; tick(); dbg_wake = 0;
      check("R7 debug wake to sleep", mode_o, 2);
      irq = 1; tick(); irq = 0;
      check("R7 then active", mode_o, 1);

      // R12 external reset from deep-ram
      enter_deep(1, 6'h3f);
      ext_rst = 1; tick(); ext_rst = 0;
      check("R12 ext reset mode", mode_o, 0);
      check("R12 sys_rst", sys_rst, 1);
      check("R12 boot cold", boot_kind, 2);
      repeat (RSTC-1) tick();
      check("R12 reset dwell", mode_o, 0);
      tick();
      check("R12 back active", mode_o, 1);

      // R11 unfreeze only in active
      por();
      hib_pol = 2'b11; hib_pin = 2'b00; wake_en = 6'h3f; hib_wr = 1;
      tick(); hib_wr = 0;
      wake_src = 5'b01000; tick(); wake_src = 0;
      unfreeze = 1; tick(); unfreeze = 0;
      check("R11 unfreeze ignored in reset", io_freeze, 1);
      repeat (RSTC) tick();
      check("R11 active frozen", io_freeze, 1);
      unfreeze = 1; tick(); unfreeze = 0;
      check("R11 unfreeze in active", io_freeze, 0);

      done = 1;
      $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   end
endmodule